// File: doc/BRIEF.md
# Completion Ring with Generation-Bit Validity and Software Overflow Queue

This block is a completion queue made of a power-of-two hardware ring and a small software overflow queue. A producer pushes 32-bit completion headers into the ring, and a consumer drains completions through a valid/ready pop port. The read and write pointers run freely and are one bit wider than the slot index. Every slot keeps a generation bit, which the producer stamps from its write pointer. The reader decides whether the slot at its read pointer holds a fresh entry by comparing that stored bit with the bit it expects from its own read pointer. No shared occupancy count is needed for this decision.

The software overflow queue takes entries that were produced outside the hardware path. While that queue holds anything, its head entry is offered before the ring is looked at. Refused pushes go to a saturating overflow counter and set a sticky error flag. The port also decodes, for the entry on offer, whether it is a send-class completion.

Top module: `cq_gen_ring`

## Requirements
- R1: After reset the ring is empty: hw_empty=1, hw_full=0, hw_count=0, hw_free=2^IDX_W, out_valid=0, ovf_count=0, err_o=0.
- R2: hw_count equals the number of ring entries pushed minus the number popped. hw_free equals 2^IDX_W minus hw_count. hw_empty is 1 exactly when hw_count is 0.
- R3: hw_full is 1 exactly when hw_count equals 2^IDX_W. A ring push while hw_full=1 is refused, even when a pop happens in the same cycle, and it adds one to ovf_count (saturating at all ones) and sets err_o.
- R4: An accepted ring push stores the header with bit 10 replaced by the generation value, which is the inverse of bit IDX_W of the write pointer at that push. All other header bits are stored unchanged.
- R5: A ring entry is offered on the pop port only when its stored generation bit equals the inverse of bit IDX_W of the read pointer. Therefore out_valid=1 whenever the ring is non-empty, and out_valid=0 when both queues are empty.
- R6: While the software queue holds an entry, out_hdr shows the software queue head and out_from_sw=1, whatever the ring holds.
- R7: A pop (out_valid and out_ready both 1) removes only the entry from the queue it came from. A software pop leaves hw_count unchanged.
- R8: out_is_send is 1 exactly when out_hdr bits 3:0 hold 3, 4, 5 or 6.
- R9: err_o stays 1 from the cycle after its first refused push until the next reset.
- R10: Each queue delivers its entries in the order they were pushed, across any number of pointer wraps.
- R11: A software queue push while that queue holds 2^SWQ_IDX_W entries is refused and counted the same way as a refused ring push. Software entries are delivered unchanged, with no generation restamp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_push_valid | input | 1 | Producer push request into the ring |
| hw_push_hdr | input | 32 | Header pushed by the producer |
| sw_push_valid | input | 1 | Push request into the software queue |
| sw_push_hdr | input | 32 | Header pushed into the software queue |
| out_ready | input | 1 | Consumer accepts the offered entry |
| out_valid | output | 1 | An entry is offered |
| out_hdr | output | 32 | Offered header |
| out_from_sw | output | 1 | Offered entry comes from the software queue |
| out_is_send | output | 1 | Offered entry has a send-class opcode |
| hw_empty | output | 1 | Ring holds no entries |
| hw_full | output | 1 | Ring holds 2^IDX_W entries |
| hw_count | output | IDX_W+1 | Ring occupancy |
| hw_free | output | IDX_W+1 | Free ring slots |
| ovf_count | output | OVF_W | Saturating count of refused pushes |
| err_o | output | 1 | Sticky error flag |

## Verification
On every cycle the assertions tie the generation-bit validity to the pointer-based empty flag. They also check that occupancy and free count always add up to the ring size, that a full ring stays full unless a ring entry leaves, and that a software pop leaves the ring occupancy alone. The stickiness of the error flag and the send-opcode decode are also checked each cycle. Only the bench's reference queues can show that headers come out in push order with the correct generation stamp across many wraps. The same holds for the software queue's precedence over a non-empty ring and for the exact number of refused pushes.

// File: rtl/cqr_pkg.sv
package cqr_pkg;

  // Completion header layout; the generation bit position is decoded by the reader.
  typedef struct packed {
    logic        ooo;
    logic [18:0] qp;
    logic        swgen;
    logic        gen;
    logic [4:0]  status;
    logic        kind;
    logic [3:0]  opc;
  } cq_hdr_t;

  function automatic logic is_send_opc(input logic [3:0] opc);
    return (opc >= 4'd3) && (opc <= 4'd6);
  endfunction

endpackage

// File: rtl/cqr_hw_ring.sv
module cqr_hw_ring #(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_req,
  input  logic [31:0]      push_hdr,
  input  logic             pop_en,
  output logic             head_vld,
  output logic [31:0]      head_hdr,
  output logic             empty,
  output logic             full,
  output logic [IDX_W:0]   count,
  output logic [IDX_W:0]   free
);
  import cqr_pkg::*;

  localparam int DEPTH = 1 << IDX_W;
  localparam int PTR_W = IDX_W + 1;

  logic [PTR_W-1:0] wptr_q, wptr_d, rptr_q, rptr_d, occ;
  logic [DEPTH-1:0] gen_q, gen_d;
  logic [31:0]      mem [DEPTH];
  logic [IDX_W-1:0] widx, ridx;
  logic             push_ok, pop_ok, wgen, rgen_exp;
  cq_hdr_t          stamped;

  assign widx     = wptr_q[IDX_W-1:0];
  assign ridx     = rptr_q[IDX_W-1:0];
  assign occ      = wptr_q - rptr_q;
  assign empty    = (wptr_q == rptr_q);
  assign full     = occ[IDX_W] && (wptr_q != rptr_q);
  assign count    = occ;
  assign free     = PTR_W'(DEPTH) - occ;
  assign wgen     = ~wptr_q[IDX_W];
  assign rgen_exp = ~rptr_q[IDX_W];
  assign head_vld = (gen_q[ridx] == rgen_exp);
  assign head_hdr = mem[ridx];
  assign push_ok  = push_req && !full;
  assign pop_ok   = pop_en && head_vld;

  always_comb begin
    stamped     = cq_hdr_t'(push_hdr);
    stamped.gen = wgen;
    wptr_d      = wptr_q;
    rptr_d      = rptr_q;
    gen_d       = gen_q;
    if (push_ok) begin
      wptr_d      = wptr_q + PTR_W'(1);
      gen_d[widx] = wgen;
    end
    if (pop_ok) rptr_d = rptr_q + PTR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      gen_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      gen_q  <= gen_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[widx] <= stamped;
  end

endmodule

// File: rtl/cqr_sw_fifo.sv
module cqr_sw_fifo #(
  parameter int IDX_W = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        push_req,
  input  logic [31:0] push_hdr,
  input  logic        pop_en,
  output logic        push_ok,
  output logic        nonempty,
  output logic [31:0] head_hdr
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int PTR_W = IDX_W + 1;

  logic [PTR_W-1:0] wptr_q, wptr_d, rptr_q, rptr_d, occ;
  logic [31:0]      mem [DEPTH];
  logic             full;

  assign occ      = wptr_q - rptr_q;
  assign full     = occ[IDX_W];
  assign nonempty = (wptr_q != rptr_q);
  assign push_ok  = push_req && !full;
  assign head_hdr = mem[rptr_q[IDX_W-1:0]];

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    if (push_ok)             wptr_d = wptr_q + PTR_W'(1);
    if (pop_en && nonempty)  rptr_d = rptr_q + PTR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr_q[IDX_W-1:0]] <= push_hdr;
  end

endmodule

// File: rtl/cq_gen_ring.sv
module cq_gen_ring #(
  parameter int IDX_W     = 3,
  parameter int SWQ_IDX_W = 2,
  parameter int OVF_W     = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hw_push_valid,
  input  logic [31:0]        hw_push_hdr,
  input  logic               sw_push_valid,
  input  logic [31:0]        sw_push_hdr,
  input  logic               out_ready,
  output logic               out_valid,
  output logic [31:0]        out_hdr,
  output logic               out_from_sw,
  output logic               out_is_send,
  output logic               hw_empty,
  output logic               hw_full,
  output logic [IDX_W:0]     hw_count,
  output logic [IDX_W:0]     hw_free,
  output logic [OVF_W-1:0]   ovf_count,
  output logic               err_o
);
  import cqr_pkg::*;

  logic        sw_nonempty, sw_push_ok, hw_head_vld, pop_fire, sw_pop, hw_pop;
  logic        hw_drop, sw_drop;
  logic [31:0] sw_head, hw_head;
  logic [OVF_W:0]   ovf_sum;
  logic [OVF_W-1:0] ovf_q, ovf_d;
  logic        err_q, err_d;

  assign out_valid   = sw_nonempty || hw_head_vld;
  assign out_from_sw = sw_nonempty;
  assign out_hdr     = sw_nonempty ? sw_head : hw_head;
  assign out_is_send = is_send_opc(out_hdr[3:0]);
  assign pop_fire    = out_valid && out_ready;
  assign sw_pop      = pop_fire && sw_nonempty;
  assign hw_pop      = pop_fire && !sw_nonempty;

  cqr_hw_ring #(.IDX_W(IDX_W)) ring_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_req (hw_push_valid),
    .push_hdr (hw_push_hdr),
    .pop_en   (hw_pop),
    .head_vld (hw_head_vld),
    .head_hdr (hw_head),
    .empty    (hw_empty),
    .full     (hw_full),
    .count    (hw_count),
    .free     (hw_free)
  );

  cqr_sw_fifo #(.IDX_W(SWQ_IDX_W)) swq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_req (sw_push_valid),
    .push_hdr (sw_push_hdr),
    .pop_en   (sw_pop),
    .push_ok  (sw_push_ok),
    .nonempty (sw_nonempty),
    .head_hdr (sw_head)
  );

  assign hw_drop = hw_push_valid && hw_full;
  assign sw_drop = sw_push_valid && !sw_push_ok;

  always_comb begin
    ovf_sum = {1'b0, ovf_q} + (OVF_W+1)'(hw_drop) + (OVF_W+1)'(sw_drop);
    ovf_d   = ovf_sum[OVF_W] ? '1 : ovf_sum[OVF_W-1:0];
    err_d   = err_q || hw_drop || sw_drop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= '0;
      err_q <= 1'b0;
    end else begin
      ovf_q <= ovf_d;
      err_q <= err_d;
    end
  end

  assign ovf_count = ovf_q;
  assign err_o     = err_q;

endmodule

// File: rtl/cq_gen_ring_chk.sv
module cq_gen_ring_chk #(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hw_push_valid,
  input logic             out_valid,
  input logic             out_ready,
  input logic [31:0]      out_hdr,
  input logic             out_from_sw,
  input logic             out_is_send,
  input logic             hw_empty,
  input logic             hw_full,
  input logic [IDX_W:0]   hw_count,
  input logic [IDX_W:0]   hw_free,
  input logic             err_o
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int PTR_W = IDX_W + 1;

  AST_ROOM_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, hw_count} + {1'b0, hw_free}) == (PTR_W+1)'(DEPTH)); // R2
  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    hw_empty == (hw_count == '0)); // R2
  AST_FULL_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    hw_full == (hw_count == PTR_W'(DEPTH))); // R3
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_full && !(out_valid && out_ready && !out_from_sw)) |=> hw_full); // R3
  AST_FULL_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_full && hw_push_valid) |=> err_o); // R3
  AST_RING_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    !hw_empty |-> out_valid); // R5
  AST_HW_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_from_sw) |-> !hw_empty); // R5
  AST_SW_POP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_from_sw && !hw_push_valid) |=> hw_count == $past(hw_count)); // R7
  AST_SEND_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_is_send == (out_hdr[3:0] >= 4'd3 && out_hdr[3:0] <= 4'd6))); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o); // R9

endmodule

bind cq_gen_ring cq_gen_ring_chk #(.IDX_W(IDX_W)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .hw_push_valid (hw_push_valid),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_hdr       (out_hdr),
  .out_from_sw   (out_from_sw),
  .out_is_send   (out_is_send),
  .hw_empty      (hw_empty),
  .hw_full       (hw_full),
  .hw_count      (hw_count),
  .hw_free       (hw_free),
  .err_o         (err_o)
);

// File: tb/cq_gen_ring_tb.sv
module cq_gen_ring_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W      = 3;
  localparam int SWQ_IDX_W  = 2;
  localparam int OVF_W      = 8;
  localparam int DEPTH      = 1 << IDX_W;
  localparam int SW_DEPTH   = 1 << SWQ_IDX_W;
  localparam int OVF_MAX    = (1 << OVF_W) - 1;

  logic clk, rst_n;
  logic hw_push_valid, sw_push_valid, out_ready;
  logic [31:0] hw_push_hdr, sw_push_hdr;
  logic out_valid, out_from_sw, out_is_send, hw_empty, hw_full, err_o;
  logic [31:0] out_hdr;
  logic [IDX_W:0] hw_count, hw_free;
  logic [OVF_W-1:0] ovf_count;

  int n_checks = 0;
  int n_fail   = 0;

  logic [31:0] hw_q[$];
  logic [31:0] sw_q[$];
  int m_wptr, m_ovf;
  bit m_err;

  cq_gen_ring #(.IDX_W(IDX_W), .SWQ_IDX_W(SWQ_IDX_W), .OVF_W(OVF_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .hw_push_valid(hw_push_valid), .hw_push_hdr(hw_push_hdr),
    .sw_push_valid(sw_push_valid), .sw_push_hdr(sw_push_hdr),
    .out_ready(out_ready), .out_valid(out_valid), .out_hdr(out_hdr),
    .out_from_sw(out_from_sw), .out_is_send(out_is_send),
    .hw_empty(hw_empty), .hw_full(hw_full), .hw_count(hw_count), .hw_free(hw_free),
    .ovf_count(ovf_count), .err_o(err_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] stamp(input logic [31:0] h, input int wp);
    logic [31:0] s;
    s = h;
    s[10] = ~wp[IDX_W];
    return s;
  endfunction

  function automatic logic send_exp(input logic [31:0] h);
    return (h[3:0] >= 4'd3) && (h[3:0] <= 4'd6);
  endfunction

  task automatic model_reset();
    hw_q.delete();
    sw_q.delete();
    m_wptr = 0;
    m_ovf  = 0;
    m_err  = 0;
  endtask

  task automatic check_outputs();
    logic vexp;
    logic [31:0] hexp;
    vexp = (sw_q.size() > 0) || (hw_q.size() > 0);
    chk("R5 out_valid", 32'(out_valid), 32'(vexp));
    if (vexp) begin
      if (sw_q.size() > 0) begin
        hexp = sw_q[0];
        chk("R6 out_from_sw", 32'(out_from_sw), 32'd1);
        chk("R11 R10 sw head", out_hdr, hexp);
      end else begin
        hexp = hw_q[0];
        chk("R6 out_from_sw", 32'(out_from_sw), 32'd0);
        chk("R4 R10 ring head", out_hdr, hexp);
      end
      chk("R8 out_is_send", 32'(out_is_send), 32'(send_exp(hexp)));
    end
    chk("R2 R7 hw_count", 32'(hw_count), 32'(hw_q.size()));
    chk("R2 hw_free", 32'(hw_free), 32'(DEPTH - hw_q.size()));
    chk("R2 hw_empty", 32'(hw_empty), 32'(hw_q.size() == 0));
    chk("R3 hw_full", 32'(hw_full), 32'(hw_q.size() == DEPTH));
    chk("R3 R11 ovf_count", 32'(ovf_count), 32'(m_ovf));
    chk("R9 err_o", 32'(err_o), 32'(m_err));
  endtask

  task automatic step(input bit hv, input logic [31:0] hh, input bit sv,
                      input logic [31:0] sh, input bit rdy);
    bit hfull, sfull, any;
    @(negedge clk);
    hw_push_valid = hv; hw_push_hdr = hh;
    sw_push_valid = sv; sw_push_hdr = sh;
    out_ready = rdy;
    #1;
    check_outputs();
    hfull = (hw_q.size() == DEPTH);
    sfull = (sw_q.size() == SW_DEPTH);
    any   = (sw_q.size() > 0) || (hw_q.size() > 0);
    if (any && rdy) begin
      if (sw_q.size() > 0) void'(sw_q.pop_front());
      else                 void'(hw_q.pop_front());
    end
    if (hv) begin
      if (hfull) begin m_ovf++; m_err = 1; end
      else begin
        hw_q.push_back(stamp(hh, m_wptr));
        m_wptr = (m_wptr + 1) % (2 * DEPTH);
      end
    end
    if (sv) begin
      if (sfull) begin m_ovf++; m_err = 1; end
      else sw_q.push_back(sh);
    end
    if (m_ovf > OVF_MAX) m_ovf = OVF_MAX;
  endtask

  task automatic run_rand(input int cycles, input int p_hw, input int p_sw, input int p_rdy);
    for (int i = 0; i < cycles; i++) begin
      step(($urandom % 100) < p_hw, $urandom, ($urandom % 100) < p_sw, $urandom,
           ($urandom % 100) < p_rdy);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    hw_push_valid = 0; sw_push_valid = 0; out_ready = 0;
    hw_push_hdr = '0; sw_push_hdr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    #1;
    // R1 reset state
    chk("R1 hw_empty", 32'(hw_empty), 32'd1);
    chk("R1 hw_full", 32'(hw_full), 32'd0);
    chk("R1 hw_count", 32'(hw_count), 32'd0);
    chk("R1 hw_free", 32'(hw_free), 32'(DEPTH));
    chk("R1 out_valid", 32'(out_valid), 32'd0);
    chk("R1 ovf_count", 32'(ovf_count), 32'd0);
    chk("R1 err_o", 32'(err_o), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    rst_n = 1'b0;
    hw_push_valid = 0; sw_push_valid = 0; out_ready = 0;
    hw_push_hdr = '0; sw_push_hdr = '0;
    model_reset();
    do_reset();

    // R3: fill the ring past capacity with consumer stalled
    for (int i = 0; i < DEPTH + 4; i++) step(1, $urandom, 0, '0, 0);
    // R3: push on full ring with a simultaneous pop is still refused
    step(1, 32'hFFFF_FFFF, 0, '0, 1);
    step(0, '0, 0, '0, 0);
    // R6 R11: software queue overflows and takes precedence over a non-empty ring
    for (int i = 0; i < SW_DEPTH + 1; i++) step(0, '0, 1, 32'h0000_0400 | 32'(i + 3), 0);
    for (int i = 0; i < DEPTH + SW_DEPTH + 2; i++) step(0, '0, 0, '0, 1);
    // R4 R5 R10: many pointer wraps under random traffic; R9 error stays set
    run_rand(3000, 50, 10, 60);
    // R1 R9: reset clears the sticky flag
    do_reset();
    run_rand(2000, 45, 5, 55);
    run_rand(500, 70, 0, 20);
    for (int i = 0; i < DEPTH + SW_DEPTH + 2; i++) step(0, '0, 0, '0, 1);

    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule